// File: doc/BRIEF.md
# Serial Link Bring-Up and Speed-Recovery Sequencer

This block takes a serial link controller from cold reset to a trained link. It first cycles the slot power. It then turns on the clocks and lets the reference settle before releasing the PHY. Next it pulses the endpoint reset (PERST#, active low) and forces the controller's maximum-speed field to generation 1. Only then does it enable the link training state machine (LTSSM). Every wait comes from one prescaled microsecond counter. The lengths are parameters, so a bench can shorten them.

Once training is enabled, the sequencer polls the link at a fixed period. When the link reports up and not in training, the sequencer raises `ready_o` and stays there. If a poll finds no link, it reads the PHY receiver status register over a request/acknowledge port. A speed change counts as stuck when the LTSSM sits in the receiver-lock recovery state and the receiver is not valid. In that case the sequencer forces the receiver data-enable and PLL-enable override bits on. It holds them for a set time and then clears them again, using read-modify-write accesses on both sides. If polling runs out, or the PHY reports an access error, the sequencer enters a sticky failed state.

Top module: `link_bringup_seq`

## Requirements
- R1: During and right after reset: power, clock enable, PERST#, LTSSM enable, speed field, request, ready and failed are all 0, and PHY reset is 1.
- R2: Power stays off for T_PWR_LO_US microseconds after reset. It then turns on, and a further T_PWR_HI_US wait passes before clocks are enabled.
- R3: Clock enable rises and PHY reset falls together. A T_SETTLE_US wait follows before the endpoint reset phase ends.
- R4: PERST# stays low for T_PERST_LO_US after the settle wait. It is then released, and T_PERST_HI_US passes before LTSSM enable rises. PERST# is high only while power and clock are on and PHY reset is off.
- R5: The speed field reads 1 (generation 1) from PERST# release onward, and LTSSM enable is never 1 unless the field reads 1.
- R6: Each poll waits T_POLL_US. The link is established when `link_up_i`=1 and `in_training_i`=0 at the end of that wait. `ready_o` then rises and stays high until reset.
- R7: Every poll that finds no link reads PHY address 0x100D (write-enable 0).
- R8: Recovery starts only when `ltssm_state_i`=0x0D and bit 0 of the 0x100D read data is 0. Any other combination counts the poll and returns to waiting.
- R9: Recovery reads address 0x1005 and writes it back with bits 5 and 3 set. After T_OVRD_US it reads 0x1005 again and writes it back with bits 5 and 3 cleared. All other bits keep their read value.
- R10: After MAX_POLLS polls without a link, `failed_o` rises and stays, and LTSSM enable drops.
- R11: An acknowledge that carries `phy_err_i`=1 sends the sequencer to the failed state.
- R12: A PHY request holds its address, write-enable and write data steady until the cycle it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Controller reports the link up |
| in_training_i | input | 1 | Controller reports training in progress |
| ltssm_state_i | input | 6 | Current LTSSM state code |
| phy_ack_i | input | 1 | One-cycle acknowledge of the pending PHY access |
| phy_err_i | input | 1 | Error flag, valid with the acknowledge |
| phy_rdata_i | input | 16 | PHY read data, valid with the acknowledge |
| pwr_en_o | output | 1 | Slot power enable |
| clk_en_o | output | 1 | Reference clock enable |
| phy_rst_o | output | 1 | PHY reset, active high |
| perst_n_o | output | 1 | Endpoint reset, active low |
| ltssm_en_o | output | 1 | Link training enable |
| max_speed_o | output | 4 | Maximum-speed field (1 = generation 1) |
| phy_req_o | output | 1 | PHY access request |
| phy_we_o | output | 1 | PHY access is a write |
| phy_addr_o | output | 16 | PHY register address |
| phy_wdata_o | output | 16 | PHY write data |
| ready_o | output | 1 | Link established |
| failed_o | output | 1 | Bring-up failed |

## Verification
Every timed phase lasts exactly length×CLK_PER_US+1 cycles from the edge that enters it. The first phase is the exception: it lasts length×CLK_PER_US cycles counted from the first edge after reset release. A PHY access lasts exactly as many cycles as the responder's acknowledge latency. The decision taken on the acknowledge (or on a poll's end) shows on the outputs in the very next cycle. The bench's reference model steps through these phase lengths with plain integer counts. It compares every output at each falling edge, so any result that comes a cycle early or late shows up as a mismatch in that cycle.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [3:0] {
    ST_PWR_LO     = 4'd0,
    ST_PWR_HI     = 4'd1,
    ST_CLK_SETTLE = 4'd2,
    ST_PERST_LO   = 4'd3,
    ST_PERST_HI   = 4'd4,
    ST_POLL_WAIT  = 4'd5,
    ST_RD_RX      = 4'd6,
    ST_RD_OVR1    = 4'd7,
    ST_WR_OVR1    = 4'd8,
    ST_OVR_HOLD   = 4'd9,
    ST_RD_OVR2    = 4'd10,
    ST_WR_OVR2    = 4'd11,
    ST_READY      = 4'd12,
    ST_FAILED     = 4'd13
  } lbs_state_e;

  localparam logic [15:0] RX_STAT_ADDR   = 16'h100D;
  localparam logic [15:0] OVRD_ADDR      = 16'h1005;
  localparam logic [15:0] OVRD_BITS      = 16'h0028;  // bit 5 data enable, bit 3 PLL enable
  localparam logic [5:0]  LTSSM_RCV_LOCK = 6'h0D;
  localparam logic [3:0]  SPEED_GEN1     = 4'd1;

  function automatic logic link_established(input logic up, input logic training);
    return up && !training;
  endfunction

  function automatic logic speed_change_stuck(input logic [5:0] st, input logic rx_valid);
    return (st == LTSSM_RCV_LOCK) && !rx_valid;
  endfunction

  function automatic logic [15:0] ovrd_force(input logic [15:0] v);
    return v | OVRD_BITS;
  endfunction

  function automatic logic [15:0] ovrd_release(input logic [15:0] v);
    return v & ~OVRD_BITS;
  endfunction

endpackage

// File: rtl/lbs_timer.sv
module lbs_timer #(
  parameter int unsigned CLK_PER_US = 100,
  parameter int unsigned LEN_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  localparam int unsigned PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] us_q;
  logic             us_tick;

  assign us_tick = (pre_q == PRE_LAST);
  assign done_o  = (us_q == len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (!done_o) begin
      pre_q <= us_tick ? '0 : pre_q + 1'b1;
      if (us_tick) us_q <= us_q + 1'b1;
    end
  end

  // R2: the microsecond count never runs past the current phase length
  a_r2_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    us_q <= len_i);

endmodule

// File: rtl/lbs_phy_port.sv
module lbs_phy_port import lbs_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  lbs_state_e  state_i,
  input  logic        ack_i,
  input  logic [15:0] rdata_i,
  output logic        req_o,
  output logic        we_o,
  output logic [15:0] addr_o,
  output logic [15:0] wdata_o,
  output logic        acked_o
);
  logic [15:0] ovrd_q;
  logic        is_rd_ovr;

  assign is_rd_ovr = (state_i == ST_RD_OVR1) || (state_i == ST_RD_OVR2);

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_RD_RX:   begin req_o = 1'b1; addr_o = RX_STAT_ADDR; end
      ST_RD_OVR1,
      ST_RD_OVR2: begin req_o = 1'b1; addr_o = OVRD_ADDR; end
      ST_WR_OVR1: begin req_o = 1'b1; we_o = 1'b1; addr_o = OVRD_ADDR; wdata_o = ovrd_force(ovrd_q); end
      ST_WR_OVR2: begin req_o = 1'b1; we_o = 1'b1; addr_o = OVRD_ADDR; wdata_o = ovrd_release(ovrd_q); end
      default: ;
    endcase
  end

  assign acked_o = req_o && ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovrd_q <= '0;
    else if (is_rd_ovr && ack_i)   ovrd_q <= rdata_i;
  end

  // R12: an unacknowledged request keeps its fields
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq import lbs_pkg::*; #(
  parameter int unsigned CLK_PER_US    = 100,
  parameter int unsigned T_PWR_LO_US   = 20000,
  parameter int unsigned T_PWR_HI_US   = 20000,
  parameter int unsigned T_SETTLE_US   = 50000,
  parameter int unsigned T_PERST_LO_US = 20000,
  parameter int unsigned T_PERST_HI_US = 20000,
  parameter int unsigned T_POLL_US     = 10,
  parameter int unsigned T_OVRD_US     = 3000,
  parameter int unsigned MAX_POLLS     = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up_i,
  input  logic        in_training_i,
  input  logic [5:0]  ltssm_state_i,
  input  logic        phy_ack_i,
  input  logic        phy_err_i,
  input  logic [15:0] phy_rdata_i,
  output logic        pwr_en_o,
  output logic        clk_en_o,
  output logic        phy_rst_o,
  output logic        perst_n_o,
  output logic        ltssm_en_o,
  output logic [3:0]  max_speed_o,
  output logic        phy_req_o,
  output logic        phy_we_o,
  output logic [15:0] phy_addr_o,
  output logic [15:0] phy_wdata_o,
  output logic        ready_o,
  output logic        failed_o
);
  localparam int unsigned LEN_W  = 32;
  localparam int unsigned POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

  lbs_state_e        state_q, state_d;
  logic [LEN_W-1:0]  wait_len;
  logic              timer_done;
  logic              timer_clr;
  logic              acked;
  logic              acc_err;
  logic              link_ok;
  logic              stuck;
  logic              last_poll;
  logic              poll_done;
  logic [POLL_W-1:0] poll_q;

  assign link_ok   = link_established(link_up_i, in_training_i);
  assign stuck     = speed_change_stuck(ltssm_state_i, phy_rdata_i[0]);
  assign acc_err   = acked && phy_err_i;
  assign last_poll = (poll_q == POLL_LAST);
  assign poll_done = acked && !phy_err_i &&
                     (((state_q == ST_RD_RX) && !stuck) || (state_q == ST_WR_OVR2));

  always_comb begin
    unique case (state_q)
      ST_PWR_LO:     wait_len = LEN_W'(T_PWR_LO_US);
      ST_PWR_HI:     wait_len = LEN_W'(T_PWR_HI_US);
      ST_CLK_SETTLE: wait_len = LEN_W'(T_SETTLE_US);
      ST_PERST_LO:   wait_len = LEN_W'(T_PERST_LO_US);
      ST_PERST_HI:   wait_len = LEN_W'(T_PERST_HI_US);
      ST_POLL_WAIT:  wait_len = LEN_W'(T_POLL_US);
      ST_OVR_HOLD:   wait_len = LEN_W'(T_OVRD_US);
      default:       wait_len = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWR_LO:     if (timer_done) state_d = ST_PWR_HI;
      ST_PWR_HI:     if (timer_done) state_d = ST_CLK_SETTLE;
      ST_CLK_SETTLE: if (timer_done) state_d = ST_PERST_LO;
      ST_PERST_LO:   if (timer_done) state_d = ST_PERST_HI;
      ST_PERST_HI:   if (timer_done) state_d = ST_POLL_WAIT;
      ST_POLL_WAIT:  if (timer_done) state_d = link_ok ? ST_READY : ST_RD_RX;
      ST_RD_RX:      if (acked) state_d = acc_err ? ST_FAILED :
                                          stuck   ? ST_RD_OVR1 :
                                          last_poll ? ST_FAILED : ST_POLL_WAIT;
      ST_RD_OVR1:    if (acked) state_d = acc_err ? ST_FAILED : ST_WR_OVR1;
      ST_WR_OVR1:    if (acked) state_d = acc_err ? ST_FAILED : ST_OVR_HOLD;
      ST_OVR_HOLD:   if (timer_done) state_d = ST_RD_OVR2;
      ST_RD_OVR2:    if (acked) state_d = acc_err ? ST_FAILED : ST_WR_OVR2;
      ST_WR_OVR2:    if (acked) state_d = (acc_err || last_poll) ? ST_FAILED : ST_POLL_WAIT;
      default:       state_d = state_q;
    endcase
  end

  assign timer_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR_LO;
      poll_q  <= '0;
    end else begin
      state_q <= state_d;
      if (poll_done && !last_poll) poll_q <= poll_q + 1'b1;
    end
  end

  lbs_timer #(.CLK_PER_US(CLK_PER_US), .LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(timer_clr), .len_i(wait_len), .done_o(timer_done)
  );

  lbs_phy_port u_phy (
    .clk(clk), .rst_n(rst_n), .state_i(state_q), .ack_i(phy_ack_i), .rdata_i(phy_rdata_i),
    .req_o(phy_req_o), .we_o(phy_we_o), .addr_o(phy_addr_o), .wdata_o(phy_wdata_o),
    .acked_o(acked)
  );

  assign pwr_en_o    = (state_q >= ST_PWR_HI);
  assign clk_en_o    = (state_q >= ST_CLK_SETTLE);
  assign phy_rst_o   = (state_q <  ST_CLK_SETTLE);
  assign perst_n_o   = (state_q >= ST_PERST_HI);
  assign max_speed_o = perst_n_o ? SPEED_GEN1 : 4'd0;
  assign ltssm_en_o  = (state_q >= ST_POLL_WAIT) && (state_q != ST_FAILED);
  assign ready_o     = (state_q == ST_READY);
  assign failed_o    = (state_q == ST_FAILED);

  // R4: endpoint released only with power and clock up and PHY out of reset
  a_r4_perst_order: assert property (@(posedge clk) disable iff (!rst_n)
    perst_n_o |-> (pwr_en_o && clk_en_o && !phy_rst_o));
  // R4: training never starts in the same cycle the endpoint is released
  a_r4_perst_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n_o) |-> !ltssm_en_o);
  // R5: training enabled only with generation 1 forced
  a_r5_gen1_first: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_en_o |-> (max_speed_o == SPEED_GEN1));
  // R6: ready is sticky
  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
  // R10: failure is sticky and stops training
  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    failed_o |=> (failed_o && !ltssm_en_o && !ready_o));
  // R11: an errored acknowledge ends in failure
  a_r11_err_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req_o && phy_ack_i && phy_err_i) |=> failed_o);

endmodule

// File: tb/test_link_bringup_seq.sv
module test_link_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int PLO = 3, PHI = 2, SET = 5, PERL = 3, PERH = 2;
  localparam int POLL = 1, OVRD = 3, MAXP = 4, LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0, in_tr = 1'b0;
  logic [5:0] lt_state = 6'h00;
  logic ack = 1'b0, err = 1'b0;
  logic [15:0] rdata = 16'h0;

  logic pwr, cen, prst, perst_n, lten, req, we, rdy, fl;
  logic [3:0] spd;
  logic [15:0] addr, wdata;

  int total = 0, bad = 0;
  logic rx_valid = 1'b1;
  logic [15:0] ovrd_mem = 16'h0;
  bit err_on_write = 1'b0;
  int acc_cnt = 0;

  logic [44:0] e_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_bringup_seq #(
    .CLK_PER_US(DIV), .T_PWR_LO_US(PLO), .T_PWR_HI_US(PHI), .T_SETTLE_US(SET),
    .T_PERST_LO_US(PERL), .T_PERST_HI_US(PERH), .T_POLL_US(POLL),
    .T_OVRD_US(OVRD), .MAX_POLLS(MAXP)
  ) i_link_bringup_seq (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .in_training_i(in_tr),
    .ltssm_state_i(lt_state), .phy_ack_i(ack), .phy_err_i(err), .phy_rdata_i(rdata),
    .pwr_en_o(pwr), .clk_en_o(cen), .phy_rst_o(prst), .perst_n_o(perst_n),
    .ltssm_en_o(lten), .max_speed_o(spd), .phy_req_o(req), .phy_we_o(we),
    .phy_addr_o(addr), .phy_wdata_o(wdata), .ready_o(rdy), .failed_o(fl)
  );

  // behavioural PHY register responder: fixed acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      if (ack) acc_cnt = 0;
      ack = 1'b0; err = 1'b0;
      if (rst_n && req) begin
        acc_cnt++;
        if (acc_cnt >= LAT) begin
          ack = 1'b1;
          acc_cnt = 0;
          rdata = (addr == 16'h100D) ? {15'h0, rx_valid} : ovrd_mem;
          if (we && err_on_write) err = 1'b1;
          else if (we && addr == 16'h1005) ovrd_mem = wdata;
        end
      end
    end
  end

  function automatic logic [44:0] mk(input bit p, c, r, n, l, input logic [3:0] s,
                                     input bit q, w, input logic [15:0] a, d,
                                     input bit y, f);
    return {p, c, r, n, l, s, q, w, a, d, y, f};
  endfunction

  task automatic cmp(input string tag);
    logic [44:0] act;
    act = {pwr, cen, prst, perst_n, lten, spd, req, we, addr, wdata, rdy, fl};
    total++;
    if (act !== e_vec) begin
      bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, e_vec);
    end
  endtask

  task automatic hold(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp(tag);
    end
  endtask

  task automatic poll_base(); e_vec = mk(1,1,0,1,1,4'd1,0,0,16'h0,16'h0,0,0); endtask
  task automatic acc(input bit w, input logic [15:0] a, d);
    e_vec = mk(1,1,0,1,1,4'd1,1,w,a,d,0,0);
  endtask

  task automatic start_run();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    e_vec = mk(0,0,1,0,0,4'd0,0,0,16'h0,16'h0,0,0);
    cmp("R1");
    hold(PLO*DIV, "R2");
    e_vec = mk(1,0,1,0,0,4'd0,0,0,16'h0,16'h0,0,0);
    hold(PHI*DIV+1, "R2");
    e_vec = mk(1,1,0,0,0,4'd0,0,0,16'h0,16'h0,0,0);
    hold(SET*DIV+1, "R3");
    hold(PERL*DIV+1, "R4");
    e_vec = mk(1,1,0,1,0,4'd1,0,0,16'h0,16'h0,0,0);
    hold(PERH*DIV+1, "R5");
  endtask

  task automatic poll_wait(); poll_base(); hold(POLL*DIV+1, "R6"); endtask
  task automatic rd_rx(); acc(0, 16'h100D, 16'h0); hold(LAT, "R7_R12"); endtask
  task automatic expect_ready(); e_vec = mk(1,1,0,1,1,4'd1,0,0,16'h0,16'h0,1,0); hold(4, "R6"); endtask
  task automatic expect_fail(input string tag);
    e_vec = mk(1,1,0,1,0,4'd1,0,0,16'h0,16'h0,0,1);
    hold(4, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // link already established at first poll (R6)
    link_up = 1; in_tr = 0; lt_state = 6'h11; rx_valid = 1;
    start_run();
    poll_wait();
    expect_ready();

    // in training, LTSSM not in receiver lock: no recovery, fail after MAXP polls (R8, R10)
    link_up = 1; in_tr = 1; lt_state = 6'h0C; rx_valid = 0;
    start_run();
    for (int p = 0; p < MAXP; p++) begin
      poll_wait();
      rd_rx();
    end
    expect_fail("R10");

    // receiver lock but receiver valid: no recovery; link comes up on poll 3 (R8, R6)
    link_up = 0; in_tr = 0; lt_state = 6'h0D; rx_valid = 1;
    start_run();
    for (int p = 0; p < 2; p++) begin
      poll_wait();
      rd_rx();
    end
    link_up = 1;
    poll_wait();
    expect_ready();

    // stuck speed change: override pulse (R9)
    link_up = 0; in_tr = 0; lt_state = 6'h0D; rx_valid = 0; ovrd_mem = 16'h0108;
    start_run();
    poll_wait();
    rd_rx();
    acc(0, 16'h1005, 16'h0);    hold(LAT, "R9");
    acc(1, 16'h1005, 16'h0128); hold(LAT, "R9");
    poll_base();                hold(OVRD*DIV+1, "R9");
    acc(0, 16'h1005, 16'h0);    hold(LAT, "R9");
    acc(1, 16'h1005, 16'h0100); hold(LAT, "R9");
    total++;
    if (ovrd_mem !== 16'h0100) begin
      bad++;
      $display("FAIL R9 final override act=%h exp=%h", ovrd_mem, 16'h0100);
    end
    link_up = 1;
    poll_wait();
    expect_ready();

    // error on override write (R11)
    link_up = 0; in_tr = 0; lt_state = 6'h0D; rx_valid = 0; ovrd_mem = 16'h0000;
    err_on_write = 1;
    start_run();
    poll_wait();
    rd_rx();
    acc(0, 16'h1005, 16'h0);    hold(LAT, "R11");
    acc(1, 16'h1005, 16'h0028); hold(LAT, "R11");
    expect_fail("R11");
    err_on_write = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule